// File: doc/BRIEF.md
# Eight-Sprite Pixel Mixer with Collision Latches

This block draws up to eight movable sprites on the current scanline and merges them with the background pixel stream. Each clock it is given one dot position on the beam. For that dot it returns the colour index to show, either the background colour or the colour of the sprite that wins. The line bitmap of each sprite is 24 bits. It comes in on a shared data bus, with one load strobe per sprite. The block decides whether to accept that data, based on the sprite's vertical position and on how many lines it has already drawn.

Each sprite can have its width doubled, its height doubled, or both. A sprite can also use two-bit multicolour pixels, and it can be placed behind foreground background pixels. When sprites overlap each other, or overlap foreground graphics, the block records this in two sticky eight-bit collision registers. Each register has a one-cycle interrupt pulse. Software reads a register through a read strobe, and that read clears it.

Top module: `sprite_mixer`

## Requirements
- R1: Reset behaviour.
  - While reset is applied and just after it, both collision registers read zero and both interrupt pulses are low.
  - No sprite is visible, so the pixel output equals the background colour.
- R2: Horizontal position and hi-res dots.
  - A sprite's 9-bit X position is formed from its 8-bit low field in `spr_x_lo` plus its bit in `spr_x_hi`.
  - In hi-res mode, dot offset d = beam_x − X covers 0..23.
  - The sprite is opaque at offset d when bit 23−d of its line data is set, so the MSB is drawn first.
- R3: With `x_exp` set, each dot is drawn two beam positions wide, for 48 positions in all.
- R4: Multicolour pixels.
  - With `mc_mode` set, the line is read as twelve 2-bit pairs, MSB pair first, each pair two dots wide.
  - Pair 00 is transparent, 01 gives `mc_col_a`, 10 gives the sprite's own colour, and 11 gives `mc_col_b`.
- R5: Where opaque pixels of several sprites meet, the lowest-numbered sprite decides the output.
- R6: Behind-foreground placement.
  - If the winning sprite has its `behind_fg` bit set and `bg_fg` is high, the output is `bg_color`.
  - If that bit is clear, the sprite colour is shown over foreground.
- R7: Vertical window and line loading.
  - An inactive sprite accepts a load strobe only when beam_y equals its Y. That load starts it at line 0.
  - An active sprite takes every further load as its next line.
  - The load that would be line 21 ends the sprite instead and blanks it.
  - A load to an inactive sprite with beam_y not equal to its Y is ignored.
- R8: With `y_exp` set, the sprite stays active for 42 loads. The 43rd ends it.
- R9: A load strobe to a disabled sprite is ignored, and the sprite shows nothing.
- R10: When two or more enabled sprites are opaque at the same dot on a clock edge, all of their bits are set in `ss_coll`. The bits stay set.
- R11: When an enabled sprite is opaque while `bg_fg` is high, its bit is set in `sb_coll`. The bit stays set.
- R12: `ss_irq` or `sb_irq` pulses for one cycle when its register, after any clear from a read, goes from zero to non-zero.
- R13: Read-to-clear.
  - `rd_ss` and `rd_sb` clear their own register at the edge.
  - Bits that collide in that same cycle are kept.
  - A read of one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beam_x | input | 9 | Current dot column |
| beam_y | input | 9 | Current raster line |
| spr_x_lo | input | 64 | Low 8 bits of X, sprite i at bits 8i+7:8i |
| spr_x_hi | input | 8 | Ninth X bit, one per sprite |
| spr_y | input | 64 | Start line, sprite i at bits 8i+7:8i |
| spr_col | input | 32 | Own colour, sprite i at bits 4i+3:4i |
| mc_col_a | input | 4 | Shared colour for pair 01 |
| mc_col_b | input | 4 | Shared colour for pair 11 |
| spr_en | input | 8 | Sprite enable |
| x_exp | input | 8 | Width doubling |
| y_exp | input | 8 | Height doubling |
| mc_mode | input | 8 | Multicolour mode |
| behind_fg | input | 8 | Place sprite behind foreground |
| load_stb | input | 8 | Per-sprite line load strobe |
| load_data | input | 24 | Line bitmap for strobed sprites |
| bg_color | input | 4 | Background colour index |
| bg_fg | input | 1 | Background dot is foreground |
| rd_ss | input | 1 | Read strobe, clears sprite-sprite register |
| rd_sb | input | 1 | Read strobe, clears sprite-background register |
| pix_color | output | 4 | Final colour index for this dot |
| ss_coll | output | 8 | Sticky sprite-sprite collisions |
| sb_coll | output | 8 | Sticky sprite-background collisions |
| ss_irq | output | 1 | Pulse on sprite-sprite register becoming non-zero |
| sb_irq | output | 1 | Pulse on sprite-background register becoming non-zero |

## Verification
The bench probes the edges of each sprite window: the dot before X, dot 23 and dot 24, dot 47 and dot 48 when widened, and a position that only the ninth X bit separates from a wrong one. An off-by-one in the window compare would show a sprite colour where the background belongs. The bench places a sprite that is behind foreground over a sprite that is in front. A mixer that let the second sprite show through, instead of applying the winner's placement bit, would output the wrong colour there. The line counter is driven to exactly 21 and 42 loads, which catches a sprite that ends one line early or late. Read-to-clear is exercised on its own and while a collision happens in the same cycle. This exposes a design that drops the fresh bits or fails to raise the interrupt again.

// File: rtl/sprite_mixer.sv
module sprite_mixer #(
  parameter int NSPR = 8,
  parameter int DOTS = 24,
  parameter int ROWS = 21,
  parameter int CW   = 4,
  parameter int PW   = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PW-1:0]          beam_x,
  input  logic [PW-1:0]          beam_y,
  input  logic [NSPR*(PW-1)-1:0] spr_x_lo,
  input  logic [NSPR-1:0]        spr_x_hi,
  input  logic [NSPR*(PW-1)-1:0] spr_y,
  input  logic [NSPR*CW-1:0]     spr_col,
  input  logic [CW-1:0]          mc_col_a,
  input  logic [CW-1:0]          mc_col_b,
  input  logic [NSPR-1:0]        spr_en,
  input  logic [NSPR-1:0]        x_exp,
  input  logic [NSPR-1:0]        y_exp,
  input  logic [NSPR-1:0]        mc_mode,
  input  logic [NSPR-1:0]        behind_fg,
  input  logic [NSPR-1:0]        load_stb,
  input  logic [DOTS-1:0]        load_data,
  input  logic [CW-1:0]          bg_color,
  input  logic                   bg_fg,
  input  logic                   rd_ss,
  input  logic                   rd_sb,
  output logic [CW-1:0]          pix_color,
  output logic [NSPR-1:0]        ss_coll,
  output logic [NSPR-1:0]        sb_coll,
  output logic                   ss_irq,
  output logic                   sb_irq
);
  localparam int IW = $clog2(DOTS);
  localparam int RW = $clog2(2*ROWS+1);
  localparam int XW = PW - 1;

  logic [DOTS-1:0] dat [NSPR];
  logic [RW-1:0]   row [NSPR];
  logic [NSPR-1:0] act;
  logic [NSPR-1:0] opq;
  logic [CW-1:0]   col [NSPR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      for (int i = 0; i < NSPR; i++) begin
        dat[i] <= '0;
        row[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSPR; i++) begin
        if (load_stb[i]) begin
          if (!spr_en[i]) begin
            act[i] <= 1'b0;
            dat[i] <= '0;
          end else if (act[i]) begin
            if (row[i] + RW'(1) >= (y_exp[i] ? RW'(2*ROWS) : RW'(ROWS))) begin
              act[i] <= 1'b0;
              dat[i] <= '0;
            end else begin
              row[i] <= row[i] + RW'(1);
              dat[i] <= load_data;
            end
          end else if (beam_y == {1'b0, spr_y[i*XW +: XW]}) begin
            act[i] <= 1'b1;
            row[i] <= '0;
            dat[i] <= load_data;
          end
        end
      end
    end
  end

  logic [PW:0]     dx;
  logic [IW-1:0]   idx;
  logic [DOTS-1:0] sh;

  always_comb begin
    opq = '0;
    dx  = '0;
    idx = '0;
    sh  = '0;
    for (int i = 0; i < NSPR; i++) begin
      col[i] = spr_col[i*CW +: CW];
      dx  = {1'b0, beam_x} - {1'b0, spr_x_hi[i], spr_x_lo[i*XW +: XW]};
      idx = x_exp[i] ? dx[IW:1] : dx[IW-1:0];
      if (spr_en[i] && !dx[PW] && dx < (x_exp[i] ? (PW+1)'(2*DOTS) : (PW+1)'(DOTS))) begin
        if (mc_mode[i]) begin
          sh = dat[i] << {idx[IW-1:1], 1'b0};
          unique case (sh[DOTS-1 -: 2])
            2'b01:   begin opq[i] = 1'b1; col[i] = mc_col_a; end
            2'b10:   opq[i] = 1'b1;
            2'b11:   begin opq[i] = 1'b1; col[i] = mc_col_b; end
            default: opq[i] = 1'b0;
          endcase
        end else begin
          sh = dat[i] << idx;
          opq[i] = sh[DOTS-1];
        end
      end
    end
  end

  always_comb begin
    pix_color = bg_color;
    for (int i = NSPR-1; i >= 0; i--)
      if (opq[i]) pix_color = (behind_fg[i] && bg_fg) ? bg_color : col[i];
  end

  wire [NSPR-1:0] ss_base = rd_ss ? '0 : ss_coll;
  wire [NSPR-1:0] sb_base = rd_sb ? '0 : sb_coll;
  wire [NSPR-1:0] ss_next = ss_base | (($countones(opq) > 1) ? opq : '0);
  wire [NSPR-1:0] sb_next = sb_base | (bg_fg ? opq : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_coll <= '0;
      sb_coll <= '0;
      ss_irq  <= 1'b0;
      sb_irq  <= 1'b0;
    end else begin
      ss_coll <= ss_next;
      sb_coll <= sb_next;
      ss_irq  <= (ss_base == '0) && (ss_next != '0);
      sb_irq  <= (sb_base == '0) && (sb_next != '0);
    end
  end
endmodule

// File: rtl/sprite_mixer_chk.sv
module sprite_mixer_chk #(
  parameter int NSPR = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bg_fg,
  input logic            rd_ss,
  input logic            rd_sb,
  input logic [NSPR-1:0] ss_coll,
  input logic [NSPR-1:0] sb_coll,
  input logic            ss_irq,
  input logic            sb_irq
);
  // R12
  ss_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_irq |-> (ss_coll != '0) && (($past(ss_coll) == '0) || $past(rd_ss)));

  // R12
  sb_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_irq |-> (sb_coll != '0) && (($past(sb_coll) == '0) || $past(rd_sb)));

  // R10
  ss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ss |=> ((ss_coll & $past(ss_coll)) == $past(ss_coll)));

  // R11
  sb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sb |=> ((sb_coll & $past(sb_coll)) == $past(sb_coll)));

  // R10
  ss_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ss_coll) != 1);

  // R11
  sb_needs_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_fg && !rd_sb) |=> (sb_coll == $past(sb_coll)));
endmodule

bind sprite_mixer sprite_mixer_chk #(.NSPR(NSPR)) u_chk (.*);

// File: tb/tb_sprite_mixer.sv
module tb_sprite_mixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  beam_x = '0, beam_y = '0;
  logic [63:0] spr_x_lo = '0, spr_y = '0;
  logic [7:0]  spr_x_hi = '0;
  logic [31:0] spr_col = '0;
  logic [3:0]  mc_col_a = '0, mc_col_b = '0, bg_color = 4'd6;
  logic [7:0]  spr_en = '0, x_exp = '0, y_exp = '0, mc_mode = '0, behind_fg = '0, load_stb = '0;
  logic [23:0] load_data = '0;
  logic        bg_fg = 1'b0, rd_ss = 1'b0, rd_sb = 1'b0;
  logic [3:0]  pix_color;
  logic [7:0]  ss_coll, sb_coll;
  logic        ss_irq, sb_irq;

  int checks = 0, errors = 0, n_ss = 0, n_sb = 0;

  always #10 clk = ~clk;

  sprite_mixer dut (.*);

  always @(negedge clk) begin
    if (ss_irq) n_ss++;
    if (sb_irq) n_sb++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] mask, input logic [23:0] d, input logic [8:0] y);
    @(negedge clk);
    beam_y = y; load_data = d; load_stb = mask;
    @(negedge clk);
    load_stb = '0;
  endtask

  task automatic pix(input logic [8:0] x, input string req, input int exp);
    @(negedge clk);
    beam_x = x; bg_fg = 1'b0;
    #1 chk(req, pix_color, exp);
  endtask

  // {req, beam_x, fg, expected colour}; R2 R3 R4 R5 R6 R9
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2, 9'd99,  1'b0, 4'd6},  {4'd2, 9'd100, 1'b0, 4'd2},
    {4'd5, 9'd102, 1'b0, 4'd2},  {4'd5, 9'd103, 1'b0, 4'd2},
    {4'd5, 9'd104, 1'b0, 4'd5},  {4'd6, 9'd104, 1'b1, 4'd5},
    {4'd6, 9'd102, 1'b1, 4'd6},  {4'd6, 9'd100, 1'b1, 4'd6},
    {4'd5, 9'd120, 1'b0, 4'd2},  {4'd2, 9'd124, 1'b0, 4'd5},
    {4'd2, 9'd126, 1'b0, 4'd6},  {4'd4, 9'd200, 1'b0, 4'd9},
    {4'd3, 9'd203, 1'b0, 4'd9},  {4'd4, 9'd204, 1'b0, 4'd7},
    {4'd4, 9'd208, 1'b0, 4'd11}, {4'd4, 9'd212, 1'b0, 4'd6},
    {4'd3, 9'd247, 1'b0, 4'd6},  {4'd3, 9'd248, 1'b0, 4'd6},
    {4'd2, 9'd266, 1'b0, 4'd3},  {4'd2, 9'd267, 1'b0, 4'd6},
    {4'd2, 9'd10,  1'b0, 4'd6},  {4'd9, 9'd150, 1'b0, 4'd6}
  };

  initial begin
    #4ms;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    beam_x = 9'd10;
    repeat (3) @(negedge clk);
    chk("R1 pixel", pix_color, 6);
    chk("R1 ss", ss_coll, 0);
    chk("R1 sb", sb_coll, 0);
    chk("R1 irq", {ss_irq, sb_irq}, 0);
    rst_n = 1'b1;

    spr_x_lo[7:0] = 8'd100;  spr_y[7:0] = 8'd50;  spr_col[3:0] = 4'd2;  behind_fg[0] = 1'b1;
    spr_x_lo[15:8] = 8'd102; spr_y[15:8] = 8'd50; spr_col[7:4] = 4'd5;
    spr_x_lo[23:16] = 8'd200; spr_y[23:16] = 8'd50; spr_col[11:8] = 4'd7;
    mc_mode[2] = 1'b1; x_exp[2] = 1'b1; y_exp[2] = 1'b1;
    spr_x_lo[31:24] = 8'd10; spr_x_hi[3] = 1'b1; spr_y[31:24] = 8'd50; spr_col[15:12] = 4'd3;
    spr_x_lo[39:32] = 8'd150; spr_y[39:32] = 8'd50; spr_col[19:16] = 4'd1;
    mc_col_a = 4'd9; mc_col_b = 4'd11;
    spr_en = 8'b0000_1111;

    @(negedge clk);
    chk("R1 after reset", {ss_coll, sb_coll, ss_irq, sb_irq}, 0);
    load(8'h01, 24'hF0000F, 9'd50);
    load(8'h02, 24'hFFFFFF, 9'd50);
    load(8'h04, 24'h6C0000, 9'd50);
    load(8'h08, 24'h800000, 9'd50);
    load(8'h10, 24'hFFFFFF, 9'd50);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      beam_x = VEC[k][13:5];
      bg_fg  = VEC[k][4];
      #1 chk($sformatf("R%0d table %0d", VEC[k][17:14], k), pix_color, VEC[k][3:0]);
    end

    chk("R10 ss after table", ss_coll, 8'h03);
    chk("R11 sb after table", sb_coll, 8'h03);
    chk("R12 ss irq count", n_ss, 1);
    chk("R12 sb irq count", n_sb, 1);

    @(negedge clk); beam_x = 9'd10; bg_fg = 1'b0; rd_ss = 1'b1;
    @(negedge clk); rd_ss = 1'b0;
    #1 chk("R13 ss cleared", ss_coll, 0);
    chk("R13 sb untouched", sb_coll, 8'h03);
    @(negedge clk); beam_x = 9'd102;
    @(negedge clk); beam_x = 9'd10;
    #1 chk("R10 ss relatch", ss_coll, 8'h03);
    chk("R12 ss irq again", n_ss, 2);
    @(negedge clk); beam_x = 9'd102; rd_ss = 1'b1;
    @(negedge clk); beam_x = 9'd10; rd_ss = 1'b0;
    #1 chk("R13 read with fresh hit", ss_coll, 8'h03);
    chk("R12 irq after read with hit", n_ss, 3);
    @(negedge clk); rd_sb = 1'b1;
    @(negedge clk); rd_sb = 1'b0;
    #1 chk("R13 sb cleared", sb_coll, 0);
    chk("R12 sb no irq on clear", n_sb, 1);

    for (int n = 0; n < 20; n++) load(8'h0C, 24'hEC0000, 9'd51);
    pix(9'd266, "R7 line 20 visible", 3);
    pix(9'd200, "R8 line 20 visible", 11);
    load(8'h0C, 24'hEC0000, 9'd51);
    pix(9'd266, "R7 ends after 21", 6);
    pix(9'd200, "R8 still on at 21", 11);
    for (int n = 0; n < 20; n++) load(8'h04, 24'hEC0000, 9'd52);
    pix(9'd200, "R8 line 41 visible", 11);
    load(8'h04, 24'hEC0000, 9'd52);
    pix(9'd200, "R8 ends after 42", 6);
    load(8'h08, 24'hFFFFFF, 9'd60);
    pix(9'd266, "R7 load off-line ignored", 6);
    load(8'h08, 24'h800000, 9'd50);
    pix(9'd266, "R7 restarts on its line", 3);
    load(8'h10, 24'hFFFFFF, 9'd50);
    pix(9'd150, "R9 disabled stays blank", 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule